// File: doc/BRIEF.md
# Display Mode Register Bank

This block is the register front end of a simple linear-framebuffer display controller. A synchronous request port gives software access to two windows. The mode window is a bank of 16-bit registers selected by halfword index. It holds the resolution, colour depth, enable, virtual line width and panning offsets. Two read-only values are produced on the fly in the mode window: a fixed version word and the framebuffer size counted in 64 KiB units. The extension window is 32 bits wide. It reports its own size and holds a framebuffer byte-order flag.

Every stored mode register drives a dedicated output to the scan-out logic, and so does the byte-order flag. Read data comes back one cycle after the request, marked by a valid strobe. Writes complete in the cycle they are presented.

Top module: `disp_reg_bank`

## Requirements
- R1: After reset every mode register output is zero, `bigEndianFb` is 0 (little-endian) and `rdValid` is 0.
- R2: A mode-window write (`reqWin`=0) to a byte address whose index (`reqAddr` >> 1) is below `REG_COUNT` (default 10) stores `reqWdata[15:0]` into that register. The odd and even byte addresses of a halfword select the same register.
- R3: A mode-window read of a stored index other than 0 returns the register value zero-extended to 32 bits.
- R4: A mode-window read of index 0 returns 0x0000B0C5, whatever was written there.
- R5: A mode-window read of index `REG_COUNT` (10) returns the framebuffer size divided by 65536, which is 256 for the default 16 MiB.
- R6: A mode-window read of any index above `REG_COUNT` returns 0x0000FFFF. A write to an index of `REG_COUNT` or above changes no register.
- R7: A 32-bit extension-window read (`reqWin`=1, `reqSize32`=1) at byte offset 0 returns 8. At any offset other than 0 and 4 it returns 0.
- R8: A 32-bit extension read at offset 4 returns 0xBEBEBEBE while `bigEndianFb` is 1 and 0x1E1E1E1E while it is 0.
- R9: A 32-bit extension write at offset 4 sets `bigEndianFb` only for the exact data 0xBEBEBEBE and clears it only for the exact data 0x1E1E1E1E. Any other data leaves it unchanged.
- R10: An extension-window access with `reqSize32`=0 is rejected: a write changes nothing and a read returns 0.
- R11: `rdValid` is 1 in exactly the cycle after a read request and 0 in every other cycle. `rdData` is valid in that cycle.
- R12: The mode outputs map to these indices: `xRes` 1, `yRes` 2, `bpp` 3, `enable` 4, `virtWidth` 6, `xOffset` 8, `yOffset` 9.

Indices 5 and 7 are stored and can be read back, but they have no output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWin | input | 1 | 0 = mode window, 1 = extension window |
| reqSize32 | input | 1 | Access is 32 bits wide |
| reqAddr | input | ADDR_W | Byte address within the window |
| reqWdata | input | 32 | Write data |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| xRes | output | 16 | Horizontal resolution register |
| yRes | output | 16 | Vertical resolution register |
| bpp | output | 16 | Bits-per-pixel register |
| enable | output | 16 | Enable register |
| virtWidth | output | 16 | Virtual line width register |
| xOffset | output | 16 | Horizontal panning offset |
| yOffset | output | 16 | Vertical panning offset |
| bigEndianFb | output | 1 | Framebuffer byte order, 1 = big-endian |

## Verification
The assertions watch the following on every cycle:
- the read-valid timing;
- that the byte-order flag holds unless an exact code arrives;
- that a narrow extension write or an out-of-range mode write changes nothing;
- that the version word, the all-ones value and the rejected narrow read are returned.

The bench is needed to show the rest:
- that the stored data lands in the right register and comes back correctly;
- the halfword-to-index mapping;
- the memory-size value;
- the byte-order readback codes.

It does this with a reference model driven by seeded random traffic plus directed corner cases.

// File: rtl/disp_reg_pkg.sv
package disp_reg_pkg;

  localparam int REG_W = 16;
  localparam int BUS_W = 32;

  // Mode-window register indices (scan-out logic decodes these positions)
  localparam int IDX_ID     = 0;
  localparam int IDX_XRES   = 1;
  localparam int IDX_YRES   = 2;
  localparam int IDX_BPP    = 3;
  localparam int IDX_ENABLE = 4;
  localparam int IDX_VIRTW  = 6;
  localparam int IDX_XOFF   = 8;
  localparam int IDX_YOFF   = 9;
  localparam int MIN_REGS   = 10;

  localparam logic [REG_W-1:0] VERSION_ID   = 16'hB0C5;
  localparam logic [BUS_W-1:0] ORDER_BIG    = 32'hBEBEBEBE;
  localparam logic [BUS_W-1:0] ORDER_LITTLE = 32'h1E1E1E1E;

  localparam int EXT_SIZE_OFF  = 0;
  localparam int EXT_ORDER_OFF = 4;
  localparam int EXT_WIN_BYTES = 8;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STORE,
    RD_ID,
    RD_MEMSZ,
    RD_ONES,
    RD_EXTSIZE,
    RD_ORDER
  } rdSel_e;

  typedef struct packed {
    logic   modeWe;
    logic   setBig;
    logic   setLittle;
    logic   rdReq;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/disp_reg_ctrl.sv
module disp_reg_ctrl
  import disp_reg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_COUNT = 10,
  parameter int IDX_W     = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWin,
  input  logic              reqSize32,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  output ctrlStrobe_t       strobe,
  output logic [IDX_W-1:0]  modeIdx
);

  localparam int FIDX_W = ADDR_W - 1;
  localparam logic [FIDX_W-1:0] CNT_L   = FIDX_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] SIZE_L  = ADDR_W'(EXT_SIZE_OFF);
  localparam logic [ADDR_W-1:0] ORDER_L = ADDR_W'(EXT_ORDER_OFF);

  logic [FIDX_W-1:0] fullIdx;
  logic              inRange;

  assign fullIdx = reqAddr[ADDR_W-1:1];
  assign inRange = fullIdx < CNT_L;
  assign modeIdx = fullIdx[IDX_W-1:0];

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_ZERO;
    if (reqValid) begin
      if (!reqWin) begin
        if (reqWrite) begin
          strobe.modeWe = inRange;
        end else begin
          strobe.rdReq = 1'b1;
          if (fullIdx == '0)         strobe.rdSel = RD_ID;
          else if (fullIdx == CNT_L) strobe.rdSel = RD_MEMSZ;
          else if (inRange)          strobe.rdSel = RD_STORE;
          else                       strobe.rdSel = RD_ONES;
        end
      end else begin
        if (reqWrite) begin
          if (reqSize32 && reqAddr == ORDER_L) begin
            strobe.setBig    = (reqWdata == ORDER_BIG);
            strobe.setLittle = (reqWdata == ORDER_LITTLE);
          end
        end else begin
          strobe.rdReq = 1'b1;
          if (!reqSize32)              strobe.rdSel = RD_ZERO;
          else if (reqAddr == SIZE_L)  strobe.rdSel = RD_EXTSIZE;
          else if (reqAddr == ORDER_L) strobe.rdSel = RD_ORDER;
          else                         strobe.rdSel = RD_ZERO;
        end
      end
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.modeWe, strobe.setBig, strobe.setLittle, strobe.rdReq})) else $error("AST_ONE_ACTION"); // R9

endmodule

// File: rtl/disp_reg_dp.sv
module disp_reg_dp
  import disp_reg_pkg::*;
#(
  parameter int REG_COUNT = 10,
  parameter int IDX_W     = $clog2(REG_COUNT),
  parameter int MEM_UNITS = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [IDX_W-1:0]           modeIdx,
  input  logic [BUS_W-1:0]           wrData,
  output logic [REG_COUNT*REG_W-1:0] regFlat,
  output logic                       bigEndianFb,
  output logic                       rdValid,
  output logic [BUS_W-1:0]           rdData
);

  logic [REG_W-1:0] regArr [REG_COUNT];
  logic [REG_W-1:0] storeVal;
  logic [BUS_W-1:0] rdNext;

  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN)                                    regArr[g] <= '0;
      else if (strobe.modeWe && modeIdx == IDX_W'(g)) regArr[g] <= wrData[REG_W-1:0];
    end
    assign regFlat[g*REG_W +: REG_W] = regArr[g];
  end

  always_comb begin
    storeVal = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (modeIdx == IDX_W'(i)) storeVal = regArr[i];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_STORE:   rdNext = {16'h0, storeVal};
      RD_ID:      rdNext = {16'h0, VERSION_ID};
      RD_MEMSZ:   rdNext = BUS_W'(MEM_UNITS);
      RD_ONES:    rdNext = {16'h0, 16'hFFFF};
      RD_EXTSIZE: rdNext = BUS_W'(EXT_WIN_BYTES);
      RD_ORDER:   rdNext = bigEndianFb ? ORDER_BIG : ORDER_LITTLE;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bigEndianFb <= 1'b0;
      rdValid     <= 1'b0;
      rdData      <= '0;
    end else begin
      if (strobe.setBig)         bigEndianFb <= 1'b1;
      else if (strobe.setLittle) bigEndianFb <= 1'b0;
      rdValid <= strobe.rdReq;
      if (strobe.rdReq) rdData <= rdNext;
    end
  end

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setBig && !strobe.setLittle |=> $stable(bigEndianFb)) else $error("AST_FLAG_HOLDS"); // R9
  AST_ORDER_CODE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdReq && strobe.rdSel == RD_ORDER |=> (rdData == ORDER_BIG || rdData == ORDER_LITTLE)) else $error("AST_ORDER_CODE"); // R8

endmodule

// File: rtl/disp_reg_bank.sv
module disp_reg_bank
  import disp_reg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_COUNT = 10,
  parameter int FB_LOG2   = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWin,
  input  logic              reqSize32,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic [15:0]       xRes,
  output logic [15:0]       yRes,
  output logic [15:0]       bpp,
  output logic [15:0]       enable,
  output logic [15:0]       virtWidth,
  output logic [15:0]       xOffset,
  output logic [15:0]       yOffset,
  output logic              bigEndianFb
);

  localparam int IDX_W     = $clog2(REG_COUNT + 1);
  localparam int MEM_UNITS = 1 << (FB_LOG2 - 16);
  localparam logic [ADDR_W-2:0] CNT_L = (ADDR_W-1)'(REG_COUNT);

  ctrlStrobe_t                strobe;
  logic [IDX_W-1:0]           modeIdx;
  logic [REG_COUNT*REG_W-1:0] regFlat;

  initial begin
    if (REG_COUNT < MIN_REGS) $error("REG_COUNT too small");
  end

  disp_reg_ctrl #(.ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqWin(reqWin),
    .reqSize32(reqSize32), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .strobe(strobe), .modeIdx(modeIdx)
  );

  disp_reg_dp #(.REG_COUNT(REG_COUNT), .IDX_W(IDX_W), .MEM_UNITS(MEM_UNITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeIdx(modeIdx), .wrData(reqWdata),
    .regFlat(regFlat), .bigEndianFb(bigEndianFb), .rdValid(rdValid), .rdData(rdData)
  );

  assign xRes      = regFlat[IDX_XRES*REG_W   +: REG_W];
  assign yRes      = regFlat[IDX_YRES*REG_W   +: REG_W];
  assign bpp       = regFlat[IDX_BPP*REG_W    +: REG_W];
  assign enable    = regFlat[IDX_ENABLE*REG_W +: REG_W];
  assign virtWidth = regFlat[IDX_VIRTW*REG_W  +: REG_W];
  assign xOffset   = regFlat[IDX_XOFF*REG_W   +: REG_W];
  assign yOffset   = regFlat[IDX_YOFF*REG_W   +: REG_W];

  AST_RDVALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> rdValid) else $error("AST_RDVALID_RISE"); // R11
  AST_RDVALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rdValid) else $error("AST_RDVALID_IDLE"); // R11
  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && !reqWin && reqAddr[ADDR_W-1:1] == '0 |=> rdData == {16'h0, VERSION_ID}) else $error("AST_VERSION_READ"); // R4
  AST_OOR_READ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && !reqWin && reqAddr[ADDR_W-1:1] > CNT_L |=> rdData == 32'h0000FFFF) else $error("AST_OOR_READ"); // R6
  AST_OOR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && !reqWin && reqAddr[ADDR_W-1:1] >= CNT_L |=> $stable(regFlat)) else $error("AST_OOR_WRITE"); // R6
  AST_NARROW_EXT_WR: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && reqWin && !reqSize32 |=> $stable(bigEndianFb) && $stable(regFlat)) else $error("AST_NARROW_EXT_WR"); // R10
  AST_NARROW_EXT_RD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && reqWin && !reqSize32 |=> rdData == '0) else $error("AST_NARROW_EXT_RD"); // R10

endmodule

// File: tb/disp_reg_bank_tb.sv
module disp_reg_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqWin = 1'b0, reqSize32 = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rdValid, bigEndianFb;
  logic [31:0] rdData;
  logic [15:0] xRes, yRes, bpp, enable, virtWidth, xOffset, yOffset;

  int testCnt = 0;
  int failCnt = 0;
  logic [15:0] model [10];
  bit          mFlag;

  always #5 clk = ~clk;

  disp_reg_bank dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqWin(reqWin),
    .reqSize32(reqSize32), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .xRes(xRes), .yRes(yRes), .bpp(bpp),
    .enable(enable), .virtWidth(virtWidth), .xOffset(xOffset), .yOffset(yOffset),
    .bigEndianFb(bigEndianFb)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(bit win, bit s32, logic [7:0] a);
    int idx = int'(a >> 1);
    if (!win) begin
      if (idx == 0)  return 32'h0000B0C5;
      if (idx == 10) return 32'd256;
      if (idx > 10)  return 32'h0000FFFF;
      return {16'h0, model[idx]};
    end
    if (!s32)   return 32'h0;
    if (a == 0) return 32'd8;
    if (a == 4) return mFlag ? 32'hBEBEBEBE : 32'h1E1E1E1E;
    return 32'h0;
  endfunction

  function automatic string readTag(bit win, bit s32, logic [7:0] a);
    int idx = int'(a >> 1);
    if (!win) begin
      if (idx == 0)  return "R4 version";
      if (idx == 10) return "R5 memsize";
      if (idx > 10)  return "R6 oor read";
      return "R3 readback";
    end
    if (!s32)   return "R10 narrow read";
    if (a == 4) return "R8 order read";
    return "R7 ext read";
  endfunction

  task automatic checkPorts(string tag);
    check({tag, " R12 xRes"}, {16'h0, xRes}, {16'h0, model[1]});
    check({tag, " R12 yRes"}, {16'h0, yRes}, {16'h0, model[2]});
    check({tag, " R12 bpp"}, {16'h0, bpp}, {16'h0, model[3]});
    check({tag, " R12 enable"}, {16'h0, enable}, {16'h0, model[4]});
    check({tag, " R12 virtWidth"}, {16'h0, virtWidth}, {16'h0, model[6]});
    check({tag, " R12 xOffset"}, {16'h0, xOffset}, {16'h0, model[8]});
    check({tag, " R12 yOffset"}, {16'h0, yOffset}, {16'h0, model[9]});
    check({tag, " R9 flag"}, {31'h0, bigEndianFb}, {31'h0, mFlag});
  endtask

  task automatic doWrite(bit win, bit s32, logic [7:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqWin = win; reqSize32 = s32; reqAddr = a; reqWdata = d;
    if (!win) begin
      if ((a >> 1) < 10) model[a >> 1] = d[15:0];
    end else if (s32 && a == 8'd4) begin
      if (d == 32'hBEBEBEBE) mFlag = 1'b1;
      if (d == 32'h1E1E1E1E) mFlag = 1'b0;
    end
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    check("R11 no rdValid after write", {31'h0, rdValid}, 32'h0);
    checkPorts(tag);
  endtask

  task automatic doRead(bit win, bit s32, logic [7:0] a);
    logic [31:0] e;
    e = expRead(win, s32, a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqWin = win; reqSize32 = s32; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check("R11 rdValid", {31'h0, rdValid}, 32'h1);
    check(readTag(win, s32, a), rdData, e);
    @(negedge clk);
    check("R11 rdValid single", {31'h0, rdValid}, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  a;
    bit          w, s;
    for (int i = 0; i < 10; i++) model[i] = '0;
    mFlag = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkPorts("R1 reset");
    check("R1 rdValid reset", {31'h0, rdValid}, 32'h0);

    // Directed corner cases
    doWrite(0, 0, 8'h03, 32'hABCD1234, "R2 odd addr");
    check("R2 xRes low half", {16'h0, xRes}, 32'h1234);
    doRead(0, 0, 8'h02);
    doWrite(0, 1, 8'h00, 32'h00001111, "R4 write id");
    doRead(0, 0, 8'h00);
    doRead(0, 0, 8'h14);
    doWrite(0, 0, 8'h14, 32'h0000BEEF, "R6 write memsize idx");
    doWrite(0, 0, 8'h50, 32'h0000CAFE, "R6 write oor");
    doRead(0, 0, 8'h50);
    doRead(0, 0, 8'hFF);
    doRead(1, 1, 8'h00);
    doRead(1, 1, 8'h08);
    doRead(1, 1, 8'h04);
    doWrite(1, 1, 8'h04, 32'hBEBEBEBE, "R9 set big");
    check("R9 big set", {31'h0, bigEndianFb}, 32'h1);
    doRead(1, 1, 8'h04);
    doWrite(1, 1, 8'h04, 32'h1E1E1E1F, "R9 near miss");
    check("R9 near miss keeps", {31'h0, bigEndianFb}, 32'h1);
    doWrite(1, 0, 8'h04, 32'h1E1E1E1E, "R10 narrow write");
    check("R10 narrow keeps", {31'h0, bigEndianFb}, 32'h1);
    doRead(1, 0, 8'h00);
    doWrite(1, 1, 8'h00, 32'h1E1E1E1E, "R9 wrong offset");
    doWrite(1, 1, 8'h04, 32'h1E1E1E1E, "R9 clear");
    check("R9 cleared", {31'h0, bigEndianFb}, 32'h0);
    doRead(1, 1, 8'h04);

    // Seeded random traffic
    void'($urandom(32'h5EED0001));
    for (int n = 0; n < 400; n++) begin
      w = ($urandom_range(0, 3) == 0);
      s = ($urandom_range(0, 4) != 0);
      if (w) begin
        case ($urandom_range(0, 2))
          0: a = 8'h00;
          1: a = 8'h04;
          default: a = 8'($urandom_range(0, 15));
        endcase
      end else begin
        a = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'($urandom_range(0, 23));
      end
      case ($urandom_range(0, 3))
        0: d = 32'hBEBEBEBE;
        1: d = 32'h1E1E1E1E;
        default: d = $urandom();
      endcase
      if ($urandom_range(0, 1) == 0) doWrite(w, s, a, d, "R2 random write");
      else doRead(w, s, a);
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule